// File: doc/BRIEF.md
# Command-Buffer Control-Area Sequencer

This block sequences a shared-buffer command interface through four phases: idle, ready, executing and complete. Host software writes three registers through a simple write port. The request register carries two write-1-to-set bits, command-ready and go-idle, which the block clears to acknowledge them. The start register launches a command. The cancel register asks for the running command to be abandoned. The block reports an idle flag and a sticky fatal-error flag. It drives an execute strobe to a command engine, raises an abort flag toward it on cancellation, and takes a one-cycle done pulse back.

Leaving idle needs a wake acknowledge from the engine side. A request can therefore stall. A cycle counter limits how long any request may stay unacknowledged outside execution. If the limit is reached, the fatal flag is raised and stays set until reset.

Top module: `cbuf_ctrl_area`

## Requirements
- R1: After reset, state_o is 0 (idle; the encoding is 0 idle, 1 ready, 2 executing, 3 complete), req_o, start_o and cancel_o are 0, and sts_o is 2'b10 (bit 1 idle flag, bit 0 fatal flag).
- R2: A write with wr_sel_i=0 sets the request bits named by wr_data_i. Bit 0 is command-ready and bit 1 is go-idle. In idle, a pending command-ready with wake_ack_i high moves the block to ready on the next edge. The same edge clears req_o[0] and drops sts_o[1].
- R3: A pending go-idle in ready or complete moves the block to idle on the next edge, clears req_o[1] and raises sts_o[1]. In idle, a pending go-idle is simply cleared.
- R4: Writing 1 to the start register (wr_sel_i=1, wr_data_i[0]) in ready sets start_o. The next edge enters executing with exec_o high.
- R5: A start write in any state other than ready leaves start_o and state_o unchanged.
- R6: A done_i pulse during executing moves the block to complete on that edge and clears start_o on the same edge.
- R7: A go-idle set during executing stays pending in req_o[1] until completion, and is then taken on the next edge.
- R8: A write with wr_sel_i=2 stores wr_data_i[0] into the cancel register, which reads back on cancel_o. Writing 0 clears it. Outside executing it changes no state.
- R9: With cancel_o high during executing, abort_o is high, and the next edge enters complete with start_o cleared.
- R10: When a request bit has been pending outside executing for TIMEOUT_CYC consecutive edges, sts_o[0] is set. An acknowledge on an earlier edge leaves it at 0.
- R11: Once set, sts_o[0] stays set through further traffic until rst_ni is asserted.
- R12: In complete, a command-ready moves the block to ready. In ready, a command-ready is acknowledged and the block stays in ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Target: 0 request, 1 start, 2 cancel, 3 none |
| wr_data_i | input | 2 | Write data |
| wake_ack_i | input | 1 | Engine is awake; gates leaving idle |
| done_i | input | 1 | Engine finished the command (pulse) |
| req_o | output | 2 | Pending request bits {go-idle, command-ready} |
| sts_o | output | 2 | Status {idle, fatal} |
| start_o | output | 1 | Start register |
| cancel_o | output | 1 | Cancel register |
| state_o | output | 2 | Current phase |
| exec_o | output | 1 | Engine execute strobe |
| abort_o | output | 1 | Cancelled flag toward the engine |

## Verification
A wrong phase shows on state_o and sts_o[1] one edge after the triggering write. A mishandled acknowledge shows as a request bit that stays set, or clears early, on that same edge. A start register that does not drop at completion leaves start_o high on the edge that enters complete. Counter faults appear exactly at the TIMEOUT_CYC boundary: the fatal flag rises one edge too early or too late. These show within a few edges of the stimulus, so the bench samples every edge around each transition.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_EXEC  = 2'd2,
    ST_DONE  = 2'd3
  } cbuf_state_e;

  typedef enum logic [1:0] {
    SEL_REQ    = 2'd0,
    SEL_START  = 2'd1,
    SEL_CANCEL = 2'd2,
    SEL_NONE   = 2'd3
  } cbuf_sel_e;

  localparam int REQ_W    = 2;
  localparam int REQ_RDY  = 0;
  localparam int REQ_IDLE = 1;
endpackage

// File: rtl/cbuf_host_regs.sv
module cbuf_host_regs
  import cbuf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [REQ_W-1:0] wr_data_i,
  input  cbuf_state_e      state_i,
  input  logic             ack_rdy_i,
  input  logic             ack_idle_i,
  input  logic             start_clr_i,
  output logic [REQ_W-1:0] req_o,
  output logic             start_o,
  output logic             cancel_o
);
  logic [REQ_W-1:0] req_q, req_set, req_ack;
  logic             start_q, cancel_q, start_wr;

  always_comb begin
    req_set          = '0;
    req_ack          = '0;
    req_ack[REQ_RDY]  = ack_rdy_i;
    req_ack[REQ_IDLE] = ack_idle_i;
    if (wr_en_i && wr_sel_i == SEL_REQ) req_set = wr_data_i;
  end

  assign start_wr = wr_en_i && (wr_sel_i == SEL_START) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= '0;
      start_q  <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      // a fresh set wins over the acknowledge of the same edge
      req_q <= (req_q & ~req_ack) | req_set;
      if (start_clr_i)                        start_q <= 1'b0;
      else if (start_wr && state_i == ST_READY) start_q <= 1'b1;
      if (wr_en_i && wr_sel_i == SEL_CANCEL) cancel_q <= wr_data_i[0];
    end
  end

  assign req_o    = req_q;
  assign start_o  = start_q;
  assign cancel_o = cancel_q;

  assert_idle_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_EXEC && req_q[REQ_IDLE]) |=> req_q[REQ_IDLE]);
  assert_start_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr && state_i != ST_READY && !start_q) |=> !start_q);
  assert_cancel_stored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_CANCEL) |=> (cancel_q == $past(wr_data_i[0])));
endmodule

// File: rtl/cbuf_seq_fsm.sv
module cbuf_seq_fsm
  import cbuf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REQ_W-1:0] req_i,
  input  logic             start_i,
  input  logic             cancel_i,
  input  logic             wake_ack_i,
  input  logic             done_i,
  output cbuf_state_e      state_o,
  output logic             ack_rdy_o,
  output logic             ack_idle_o,
  output logic             start_clr_o
);
  cbuf_state_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    ack_rdy_o   = 1'b0;
    ack_idle_o  = 1'b0;
    start_clr_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        ack_idle_o = req_i[REQ_IDLE];
        if (req_i[REQ_RDY] && wake_ack_i) begin
          st_d      = ST_READY;
          ack_rdy_o = 1'b1;
        end
      end
      ST_READY: begin
        if (start_i) st_d = ST_EXEC;
        else if (req_i[REQ_IDLE]) begin
          st_d       = ST_IDLE;
          ack_idle_o = 1'b1;
        end else ack_rdy_o = req_i[REQ_RDY];
      end
      ST_EXEC: begin
        if (done_i || cancel_i) begin
          st_d        = ST_DONE;
          start_clr_o = 1'b1;
        end
      end
      ST_DONE: begin
        if (req_i[REQ_IDLE]) begin
          st_d       = ST_IDLE;
          ack_idle_o = 1'b1;
        end else if (req_i[REQ_RDY]) begin
          st_d      = ST_READY;
          ack_rdy_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  assert_exec_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_READY && st_q != ST_EXEC) |=> st_q != ST_EXEC);
  assert_ready_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i[REQ_RDY] && wake_ack_i) |=> st_q == ST_READY);
  assert_finish_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EXEC && (done_i || cancel_i)) |=> st_q == ST_DONE);
  assert_go_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE && req_i[REQ_IDLE]) |=> st_q == ST_IDLE);
endmodule

// File: rtl/cbuf_tmo.sv
module cbuf_tmo #(
  parameter int TIMEOUT_CYC = 20_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  output logic fatal_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             fatal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fatal_q <= 1'b0;
    end else begin
      if (!pend_i)             cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      if (pend_i && cnt_q == LIMIT) fatal_q <= 1'b1;
    end
  end

  assign fatal_o = fatal_q;

  initial assert (TIMEOUT_CYC >= 2);
  assert_fatal_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_q |=> fatal_q);
  assert_quiet_no_fatal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_i && !fatal_q) |=> !fatal_q);
endmodule

// File: rtl/cbuf_ctrl_area.sv
module cbuf_ctrl_area
  import cbuf_pkg::*;
#(
  parameter int TIMEOUT_CYC = 20_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  input  logic [1:0] wr_data_i,
  input  logic       wake_ack_i,
  input  logic       done_i,
  output logic [1:0] req_o,
  output logic [1:0] sts_o,
  output logic       start_o,
  output logic       cancel_o,
  output logic [1:0] state_o,
  output logic       exec_o,
  output logic       abort_o
);
  cbuf_state_e      state;
  logic [REQ_W-1:0] req;
  logic             start, cancel, ack_rdy, ack_idle, start_clr, fatal, pend;

  cbuf_host_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .state_i(state), .ack_rdy_i(ack_rdy), .ack_idle_i(ack_idle),
    .start_clr_i(start_clr), .req_o(req), .start_o(start), .cancel_o(cancel)
  );

  cbuf_seq_fsm u_fsm (
    .clk_i, .rst_ni, .req_i(req), .start_i(start), .cancel_i(cancel),
    .wake_ack_i, .done_i, .state_o(state), .ack_rdy_o(ack_rdy),
    .ack_idle_o(ack_idle), .start_clr_o(start_clr)
  );

  // requests parked during execution are exempt from the limit
  assign pend = (|req) && (state != ST_EXEC);

  cbuf_tmo #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
    .clk_i, .rst_ni, .pend_i(pend), .fatal_o(fatal)
  );

  assign req_o    = req;
  assign sts_o    = {state == ST_IDLE, fatal};
  assign start_o  = start;
  assign cancel_o = cancel;
  assign state_o  = state;
  assign exec_o   = (state == ST_EXEC);
  assign abort_o  = (state == ST_EXEC) && cancel;

  assert_start_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && (done_i || cancel)) |=> !start_o);
  assert_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (state_o == ST_DONE));
endmodule

// File: tb/cbuf_ctrl_area_bench.sv
module cbuf_ctrl_area_bench;
  localparam int TMO = 8;
  localparam int NV  = 20;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd3;
  logic [1:0] wr_data_i = 2'd0;
  logic       wake_ack_i = 1'b1;
  logic       done_i = 1'b0;
  logic [1:0] req_o, sts_o, state_o;
  logic       start_o, cancel_o, exec_o, abort_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cbuf_ctrl_area #(.TIMEOUT_CYC(TMO)) u_cbuf_ctrl_area (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .wake_ack_i,
    .done_i, .req_o, .sts_o, .start_o, .cancel_o, .state_o, .exec_o, .abort_o
  );

  // {tag, wr_en, sel, data, wake, done, exp_state, exp_req, exp_sts, exp_start}
  localparam logic [17:0] VEC [NV] = '{
    {4'd2,  1'b1, 2'd0, 2'b01, 1'b1, 1'b0, 2'd0, 2'b01, 2'b10, 1'b0}, // R2 set cmd-ready
    {4'd2,  1'b0, 2'd3, 2'b00, 1'b1, 1'b0, 2'd1, 2'b00, 2'b00, 1'b0}, // R2 taken
    {4'd4,  1'b1, 2'd1, 2'b01, 1'b1, 1'b0, 2'd1, 2'b00, 2'b00, 1'b1}, // R4 start
    {4'd4,  1'b0, 2'd3, 2'b00, 1'b1, 1'b0, 2'd2, 2'b00, 2'b00, 1'b1}, // R4 exec
    {4'd7,  1'b1, 2'd0, 2'b10, 1'b1, 1'b0, 2'd2, 2'b10, 2'b00, 1'b1}, // R7 go-idle in exec
    {4'd7,  1'b0, 2'd3, 2'b00, 1'b1, 1'b0, 2'd2, 2'b10, 2'b00, 1'b1}, // R7 held
    {4'd6,  1'b0, 2'd3, 2'b00, 1'b1, 1'b1, 2'd3, 2'b10, 2'b00, 1'b0}, // R6 done
    {4'd7,  1'b0, 2'd3, 2'b00, 1'b1, 1'b0, 2'd0, 2'b00, 2'b10, 1'b0}, // R7 taken
    {4'd5,  1'b1, 2'd1, 2'b01, 1'b1, 1'b0, 2'd0, 2'b00, 2'b10, 1'b0}, // R5 start in idle
    {4'd2,  1'b1, 2'd0, 2'b01, 1'b1, 1'b0, 2'd0, 2'b01, 2'b10, 1'b0}, // R2
    {4'd2,  1'b0, 2'd3, 2'b00, 1'b1, 1'b0, 2'd1, 2'b00, 2'b00, 1'b0}, // R2
    {4'd12, 1'b1, 2'd0, 2'b01, 1'b1, 1'b0, 2'd1, 2'b01, 2'b00, 1'b0}, // R12 in ready
    {4'd12, 1'b0, 2'd3, 2'b00, 1'b1, 1'b0, 2'd1, 2'b00, 2'b00, 1'b0}, // R12 acked
    {4'd4,  1'b1, 2'd1, 2'b01, 1'b1, 1'b0, 2'd1, 2'b00, 2'b00, 1'b1}, // R4
    {4'd4,  1'b0, 2'd3, 2'b00, 1'b1, 1'b0, 2'd2, 2'b00, 2'b00, 1'b1}, // R4
    {4'd6,  1'b0, 2'd3, 2'b00, 1'b1, 1'b1, 2'd3, 2'b00, 2'b00, 1'b0}, // R6
    {4'd12, 1'b1, 2'd0, 2'b01, 1'b1, 1'b0, 2'd3, 2'b01, 2'b00, 1'b0}, // R12 in complete
    {4'd12, 1'b0, 2'd3, 2'b00, 1'b1, 1'b0, 2'd1, 2'b00, 2'b00, 1'b0}, // R12 to ready
    {4'd3,  1'b1, 2'd0, 2'b10, 1'b1, 1'b0, 2'd1, 2'b10, 2'b00, 1'b0}, // R3 go-idle
    {4'd3,  1'b0, 2'd3, 2'b00, 1'b1, 1'b0, 2'd0, 2'b00, 2'b10, 1'b0}  // R3 idle
  };

  task automatic chk(input int tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] sel, input logic [1:0] d,
                      input logic wk, input logic dn);
    @(negedge clk);
    wr_en_i = we; wr_sel_i = sel; wr_data_i = d; wake_ack_i = wk; done_i = dn;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk(1, "state", state_o, 0);
    chk(1, "req", req_o, 0);
    chk(1, "sts", sts_o, 2);
    chk(1, "start", start_o, 0);
    chk(1, "cancel", cancel_o, 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13], VEC[i][12:11], VEC[i][10:9], VEC[i][8], VEC[i][7]);
      chk(int'(VEC[i][17:14]), "state", state_o, VEC[i][6:5]);
      chk(int'(VEC[i][17:14]), "req", req_o, VEC[i][4:3]);
      chk(int'(VEC[i][17:14]), "sts", sts_o, VEC[i][2:1]);
      chk(int'(VEC[i][17:14]), "start", start_o, VEC[i][0]);
    end

    // R8 cancel register outside execution
    step(1, 2, 2'b01, 1, 0);
    chk(8, "cancel set", cancel_o, 1);
    chk(8, "state", state_o, 0);
    chk(8, "abort", abort_o, 0);
    step(1, 2, 2'b00, 1, 0);
    chk(8, "cancel clr", cancel_o, 0);

    // R9 cancel during execution
    step(1, 0, 2'b01, 1, 0);
    step(0, 3, 2'b00, 1, 0);
    step(1, 1, 2'b01, 1, 0);
    step(0, 3, 2'b00, 1, 0);
    chk(9, "exec", exec_o, 1);
    step(1, 2, 2'b01, 1, 0);
    chk(9, "abort", abort_o, 1);
    chk(9, "state exec", state_o, 2);
    step(0, 3, 2'b00, 1, 0);
    chk(9, "state done", state_o, 3);
    chk(9, "start", start_o, 0);
    chk(9, "abort off", abort_o, 0);
    // R5 start in complete ignored
    step(1, 1, 2'b01, 1, 0);
    chk(5, "start", start_o, 0);
    chk(5, "state", state_o, 3);
    step(1, 2, 2'b00, 1, 0);
    step(1, 0, 2'b10, 1, 0);
    step(0, 3, 2'b00, 1, 0);
    chk(3, "state", state_o, 0);

    // R10 acknowledge one edge before the limit
    step(1, 0, 2'b01, 0, 0);
    for (int k = 0; k < TMO - 2; k++) step(0, 3, 2'b00, 0, 0);
    chk(10, "state waiting", state_o, 0);
    step(0, 3, 2'b00, 1, 0);
    chk(10, "state", state_o, 1);
    chk(10, "fatal early", sts_o[0], 0);
    step(1, 0, 2'b10, 1, 0);
    step(0, 3, 2'b00, 1, 0);

    // R10 request stalled exactly to the limit
    step(1, 0, 2'b01, 0, 0);
    for (int k = 0; k < TMO - 1; k++) step(0, 3, 2'b00, 0, 0);
    chk(10, "fatal before", sts_o[0], 0);
    step(0, 3, 2'b00, 0, 0);
    chk(10, "fatal at limit", sts_o[0], 1);

    // R11 sticky through traffic, cleared by reset
    step(0, 3, 2'b00, 1, 0);
    chk(11, "state", state_o, 1);
    step(1, 0, 2'b10, 1, 0);
    step(0, 3, 2'b00, 1, 0);
    chk(11, "fatal kept", sts_o[0], 1);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(11, "fatal after reset", sts_o[0], 0);
    chk(1, "state after reset", state_o, 0);

    finish_run();
  end
endmodule